// File: doc/BRIEF.md
# Double-Precision Floating Compare Unit

This block compares two IEEE-754 double-precision values, supplied as raw 64-bit patterns, and reports which of four relations holds: the first operand is less than, greater than or equal to the second, or the pair is unordered because a NaN is present. The comparison uses only sign-magnitude integer logic. No floating-point arithmetic is involved.

Each compare also updates a small floating status word. The caller passes in the current status bits and gets back a new copy. In the new copy the relation code is written into a result field, and the sticky exception flags are updated according to the compare mode. The unordered mode raises the invalid-operation and summary flags when it sees a NaN. The ordered mode first clears the invalid-operation flag, then sets it again together with a compare-invalid flag if it sees a NaN.

A compare begins with a one-cycle start strobe. The code, the status word and a done strobe appear on the next cycle, and the code and status word hold until the next start.

Top module: `fp_compare_unit`

## Requirements
- R1: The condition code is one-hot: 4'b1000 means less than, 4'b0100 greater than, 4'b0010 equal, and 4'b0001 unordered.
- R2: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction field (bits 51:0) is nonzero. If either operand is a NaN, whether quiet or signalling, the code is unordered.
- R3: Positive zero and negative zero compare equal in every combination.
- R4: Non-NaN values, including infinities and subnormals, are ordered by sign and then magnitude. A negative value is below a positive one. When both are negative, the magnitude ordering is reversed.
- R5: Status bits 3:0 of the returned word hold the condition code of the compare.
- R6: In unordered mode (mode input 0), a NaN sets status bit 4 (invalid operation) and bit 5 (summary). Bit 6 and bit 7 pass through unchanged.
- R7: In ordered mode (mode input 1), status bit 4 ends up equal to whether a NaN was seen. A NaN also sets bit 6 (compare invalid). Bits 5 and 7 pass through unchanged.
- R8: In unordered mode with no NaN, status bits 7:4 equal the input bits 7:4.
- R9: The done strobe is high exactly in the cycle after a start. The code and the status word update only then and hold otherwise. After reset, the code, the status word and done are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts one compare |
| ordered_i | input | 1 | 1 = ordered compare, 0 = unordered compare |
| op_a_i | input | 64 | First operand bit pattern |
| op_b_i | input | 64 | Second operand bit pattern |
| status_i | input | 8 | Current status bits |
| cc_o | output | 4 | One-hot condition code |
| status_o | output | 8 | Updated status bits |
| done_o | output | 1 | Result valid strobe |

## Verification
A table of operand pairs exercises the compare paths one at a time:
- ordinary positives, which check plain magnitude order;
- negative pairs, which catch a missing reversal;
- the two zeros in both orders, which catch a compare that treats the sign bit as significant;
- infinities against the largest finite value;
- subnormals around zero;
- quiet and signalling NaNs, including a negative NaN next to negative infinity, which separate NaN detection from infinity.

A cross sweep of a dozen representative values against a key-based reference compare covers every sign and class pairing. Directed cases cover the status word, toggling the mode and the preset flag bits to show which flags are set, cleared or passed through. Holding start low shows that the outputs hold.

// File: rtl/fp_compare_unit.sv
module fp_compare_unit #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int ST_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       ordered_i,
  input  logic [EXP_W+FRAC_W:0]      op_a_i,
  input  logic [EXP_W+FRAC_W:0]      op_b_i,
  input  logic [ST_W-1:0]            status_i,
  output logic [3:0]                 cc_o,
  output logic [ST_W-1:0]            status_o,
  output logic                       done_o
);

  localparam int W        = 1 + EXP_W + FRAC_W;
  localparam int MAG_W    = W - 1;
  localparam int INV_BIT  = 4;
  localparam int SUM_BIT  = 5;
  localparam int CMPI_BIT = 6;

  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0100;
  localparam logic [3:0] CC_EQ = 4'b0010;
  localparam logic [3:0] CC_UN = 4'b0001;

  logic             sign_a, sign_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             nan_a, nan_b, any_nan, both_zero;
  logic             mag_lt, mag_gt, a_lt, a_gt;
  logic [3:0]       cc_next;
  logic [ST_W-1:0]  st_next;

  assign sign_a = op_a_i[W-1];
  assign sign_b = op_b_i[W-1];
  assign mag_a  = op_a_i[MAG_W-1:0];
  assign mag_b  = op_b_i[MAG_W-1:0];

  assign nan_a = (&op_a_i[W-2 -: EXP_W]) && (|op_a_i[FRAC_W-1:0]);
  assign nan_b = (&op_b_i[W-2 -: EXP_W]) && (|op_b_i[FRAC_W-1:0]);
  assign any_nan = nan_a | nan_b;

  assign both_zero = ~|mag_a && ~|mag_b;
  assign mag_lt    = mag_a < mag_b;
  assign mag_gt    = mag_a > mag_b;

  always_comb begin
    if (both_zero) begin
      a_lt = 1'b0;
      a_gt = 1'b0;
    end else if (sign_a != sign_b) begin
      a_lt = sign_a;
      a_gt = sign_b;
    end else if (sign_a) begin
      a_lt = mag_gt;
      a_gt = mag_lt;
    end else begin
      a_lt = mag_lt;
      a_gt = mag_gt;
    end
  end

  assign cc_next = any_nan ? CC_UN :
                   a_lt    ? CC_LT :
                   a_gt    ? CC_GT : CC_EQ;

  always_comb begin
    st_next      = status_i;
    st_next[3:0] = cc_next;
    if (ordered_i) begin
      st_next[INV_BIT] = any_nan;
      if (any_nan) st_next[CMPI_BIT] = 1'b1;
    end else if (any_nan) begin
      st_next[INV_BIT] = 1'b1;
      st_next[SUM_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_o     <= '0;
      status_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        cc_o     <= cc_next;
        status_o <= st_next;
      end
    end
  end

  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $countones(cc_o) == 1); // R1

  AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (nan_a || nan_b) |=> cc_o == CC_UN); // R2

  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && op_a_i[W-2:0] == '0 && op_b_i[W-2:0] == '0 |=> cc_o == CC_EQ); // R3

  AST_RESULT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> status_o[3:0] == cc_o); // R5

  AST_UNORD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !ordered_i |=> status_o[SUM_BIT] >= $past(status_i[SUM_BIT])); // R6

  AST_ORD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && ordered_i && !nan_a && !nan_b |=> !status_o[INV_BIT]); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o); // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o && $stable(cc_o) && $stable(status_o)); // R9

endmodule

// File: tb/fp_compare_unit_test.sv
`timescale 1ns/1ps
module fp_compare_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        ordered_i = 1'b0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic [7:0]  status_i = '0;
  logic [3:0]  cc_o;
  logic [7:0]  status_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fp_compare_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ordered_i(ordered_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .status_i(status_i),
    .cc_o(cc_o), .status_o(status_o), .done_o(done_o)
  );

  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] MTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] MAXN = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] NSNN = 64'hFFF4_0000_0000_0000;
  localparam logic [63:0] SUBN = 64'h0000_0000_0000_0001;
  localparam logic [63:0] NSUB = 64'h8000_0000_0000_0001;

  localparam logic [3:0] LT = 4'b1000, GT = 4'b0100, EQ = 4'b0010, UN = 4'b0001;

  localparam int NV = 18;
  localparam logic [63:0] VA [NV] = '{ONE, TWO, ONE, PZ, NZ, MONE, MTWO, NINF, PINF,
                                      PINF, SUBN, NSUB, QNAN, ONE, NSNN, QNAN, SUBN, MONE};
  localparam logic [63:0] VB [NV] = '{TWO, ONE, ONE, NZ, PZ, ONE, MONE, MONE, MAXN,
                                      PINF, PZ, NZ, ONE, SNAN, NINF, QNAN, NSUB, MTWO};
  localparam logic [3:0]  VE [NV] = '{LT, GT, EQ, EQ, EQ, LT, LT, LT, GT,
                                      EQ, GT, LT, UN, UN, UN, UN, GT, GT};

  localparam int NS = 12;
  localparam logic [63:0] SW [NS] = '{PZ, NZ, ONE, MONE, MTWO, PINF, NINF, MAXN,
                                      QNAN, SNAN, SUBN, NSUB};

  function automatic bit is_nan(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic logic [63:0] key(logic [63:0] x);
    if (x[62:0] == 0) return 64'h8000_0000_0000_0000;
    return x[63] ? ~x : (x | 64'h8000_0000_0000_0000);
  endfunction

  function automatic logic [3:0] ref_cc(logic [63:0] a, logic [63:0] b);
    if (is_nan(a) || is_nan(b)) return UN;
    if (key(a) < key(b)) return LT;
    if (key(a) > key(b)) return GT;
    return EQ;
  endfunction

  function automatic logic [7:0] ref_st(bit ord, logic [3:0] cc, logic [7:0] s);
    logic [7:0] r;
    r = s;
    r[3:0] = cc;
    if (ord) begin
      r[4] = (cc == UN);
      if (cc == UN) r[6] = 1'b1;
    end else if (cc == UN) begin
      r[4] = 1'b1;
      r[5] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmp(logic [63:0] a, logic [63:0] b, bit ord, logic [7:0] s);
    @(negedge clk);
    op_a_i = a; op_b_i = b; ordered_i = ord; status_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cc_o == 0 && status_o == 0 && done_o == 0, "R9 reset",
          {status_o, cc_o, 3'b0, done_o}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] s;
      s = 8'(i * 37);
      run_cmp(VA[i], VB[i], i[0], s);
      check(done_o == 1'b1, "R9 done", done_o, 1);
      check(cc_o == VE[i], "R1 R2 R3 R4 table code", cc_o, VE[i]);
      check(status_o == ref_st(i[0], VE[i], s), "R5 R6 R7 R8 table status",
            status_o, ref_st(i[0], VE[i], s));
    end

    for (int i = 0; i < NS; i++)
      for (int j = 0; j < NS; j++) begin
        run_cmp(SW[i], SW[j], 1'b0, 8'h00);
        check(cc_o == ref_cc(SW[i], SW[j]), "R4 sweep", cc_o, ref_cc(SW[i], SW[j]));
      end

    // R9: outputs hold while start is low
    run_cmp(ONE, TWO, 1'b0, 8'h00);
    op_a_i = TWO; op_b_i = ONE; status_i = 8'hFF;
    @(negedge clk);
    check(done_o == 0 && cc_o == LT && status_o == 8'h08, "R9 hold",
          {status_o, cc_o}, {8'h08, LT});

    // R6: unordered NaN sets bits 4,5 and passes bit 7
    run_cmp(QNAN, ONE, 1'b0, 8'h80);
    check(status_o == 8'hB1, "R6 unordered nan", status_o, 8'hB1);
    // R8: unordered non-NaN keeps upper bits
    run_cmp(ONE, ONE, 1'b0, 8'hF0);
    check(status_o == 8'hF2, "R8 unordered keep", status_o, 8'hF2);
    // R7: ordered non-NaN clears bit 4, keeps 5, 6, 7
    run_cmp(MONE, ONE, 1'b1, 8'hF0);
    check(status_o == 8'hE8, "R7 ordered clear", status_o, 8'hE8);
    // R7: ordered NaN sets bits 4 and 6, leaves bit 5 low
    run_cmp(ONE, SNAN, 1'b1, 8'h00);
    check(status_o == 8'h51, "R7 ordered nan", status_o, 8'h51);
    run_cmp(NSNN, NSNN, 1'b1, 8'h20);
    check(status_o == 8'h71, "R7 ordered nan keep bit5", status_o, 8'h71);
    // R3 and R5 signed zeros in ordered mode
    run_cmp(NZ, NZ, 1'b1, 8'h10);
    check(cc_o == EQ && status_o == 8'h02, "R3 R5 zeros", {status_o, cc_o}, {8'h02, EQ});

    // R9: reset clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cc_o == 0 && status_o == 0 && done_o == 0, "R9 reset again",
          {status_o, cc_o, 3'b0, done_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule